// File: doc/BRIEF.md
# Link Settling Property Monitor

This block is a passive observer that sits beside a cycle-stepped, discretized model of a signalling link. It watches the one-bit stimulus driven into the model and the unsigned output code the model returns. It reports two verdicts. The first is a sticky legality flag: the stimulus may toggle only on a periodic slot cycle. The second is a sticky failure flag: after a legal toggle, the output code did not settle to the level that matches the new bit before the slot period ran out.

A free-running counter of period `N` marks the slot cycles. The stimulus bit is compared with its value at the previous clock edge. A difference seen on a slot edge is a legal change. It arms the settling check and starts a new window. A difference seen on any other edge clears the legality flag for good. The failure output is qualified by the legality flag, so only a trace that obeys the toggle rule can report a settling failure. The thresholds are parameters in output-code units. Code at or above `HI_CODE` counts as settled high. Code at or below `LO_CODE` counts as settled low.

Top module: `lnkmon`

## Requirements
- R1: While reset is asserted, and after it, until the conditions below occur, `legal_o` is 1 and `fail_o` is 0.
- R2: The internal reset is released two clock edges after `rst_n` rises. The first edge after that release is slot edge 0, and every `N`-th edge after it is also a slot edge. The stimulus reference value starts at 0 after reset.
- R3: A stimulus edge that differs from the previous edge's value (a toggle) on a non-slot edge drives `legal_o` to 0 from the next cycle.
- R4: Once `legal_o` is 0 it stays 0 until reset.
- R5: `fail_o` is 0 in every cycle in which `legal_o` is 0.
- R6: After a legal toggle to 1 on slot edge S, suppose the code is at least `HI_CODE` on some edge from S+1 through S+N-1. Then no failure is recorded for that window. Otherwise `fail_o` rises in the cycle after edge S+N-1.
- R7: After a legal toggle to 0, the same rule as R6 applies, with the condition that the code is at most `LO_CODE`.
- R8: The code sampled on the toggle edge itself does not count toward settling.
- R9: Once `fail_o` is 1 it stays 1 until reset, as long as `legal_o` stays 1.
- R10: Before the first legal toggle after reset, the code is ignored and `fail_o` stays 0.
- R11: A level reached once in a window satisfies the check. Every later window that has no toggle also passes, even if the code leaves the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stim_i | input | 1 | Stimulus bit driven into the link model |
| code_i | input | CODE_W | Unsigned output code of the link model |
| legal_o | output | 1 | Sticky flag: stimulus obeyed the slot rule |
| fail_o | output | 1 | Sticky settling failure, qualified by `legal_o` |

## Verification
Three kinds of internal error are visible at the ports. A slot counter out of phase moves the legal toggle points, so a toggle the bench expects to be legal clears `legal_o` one cycle after that edge. A wrong armed, target or reached state shows up on `fail_o` in the cycle after the last edge of a window. That can be at most `N` cycles after the toggle that opened the window. The bench compares both outputs against its own model on every cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;

  typedef struct packed {
    logic armed;
    logic want_hi;
    logic met;
    logic fail;
  } win_t;

  function automatic logic level_met(input logic want_hi, input int unsigned code,
                                     input int unsigned hi, input int unsigned lo);
    return want_hi ? (code >= hi) : (code <= lo);
  endfunction

endpackage

// File: rtl/lnkmon_slot.sv
module lnkmon_slot #(
  parameter int unsigned N = 38
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot,
  output logic last
);
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign slot = (cnt_q == '0);
  assign last = (cnt_q == CW'(N - 1));

  always_comb begin
    cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: slot edges are never adjacent (N >= 2)
  assert_slot_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot |=> !slot);

endmodule

// File: rtl/lnkmon_legal.sv
module lnkmon_legal (
  input  logic clk,
  input  logic rst_n,
  input  logic stim,
  input  logic slot,
  output logic chg_ok,
  output logic legal
);
  logic stim_q, legal_q, legal_d, chg;

  assign chg    = stim ^ stim_q;
  assign chg_ok = chg & slot;
  assign legal  = legal_q;

  always_comb begin
    legal_d = legal_q;
    if (chg && !slot) legal_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stim_q  <= 1'b0;
      legal_q <= 1'b1;
    end else begin
      stim_q  <= stim;
      legal_q <= legal_d;
    end
  end

  assert_bad_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && !slot) |=> !legal_q);

  assert_legal_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !legal_q |=> !legal_q);

endmodule

// File: rtl/lnkmon_deadline.sv
module lnkmon_deadline
  import lnkmon_pkg::*;
#(
  parameter int unsigned CODE_W  = 6,
  parameter int unsigned HI_CODE = 51,
  parameter int unsigned LO_CODE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chg_ok,
  input  logic              tgt,
  input  logic              last,
  input  logic [CODE_W-1:0] code,
  output logic              fail
);
  win_t st_q, st_d;
  logic hit;

  assign hit  = level_met(st_q.want_hi, 32'(code), HI_CODE, LO_CODE);
  assign fail = st_q.fail;

  always_comb begin
    st_d = st_q;
    if (chg_ok) begin
      st_d.armed   = 1'b1;
      st_d.want_hi = tgt;
      st_d.met     = 1'b0;
    end else begin
      if (hit) st_d.met = 1'b1;
      if (last && st_q.armed && !(st_q.met || hit)) st_d.fail = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.fail |=> st_q.fail);

  assert_unarmed_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q.armed |-> !st_q.fail);

endmodule

// File: rtl/lnkmon.sv
module lnkmon #(
  parameter int unsigned N       = 38,
  parameter int unsigned CODE_W  = 6,
  parameter int unsigned HI_CODE = 51,
  parameter int unsigned LO_CODE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stim_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              legal_o,
  output logic              fail_o
);
  logic rs1_q, rs2_q;
  logic slot, last, chg_ok, legal, fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  lnkmon_slot #(.N(N)) u_slot (
    .clk(clk), .rst_n(rs2_q), .slot(slot), .last(last)
  );

  lnkmon_legal u_legal (
    .clk(clk), .rst_n(rs2_q), .stim(stim_i), .slot(slot),
    .chg_ok(chg_ok), .legal(legal)
  );

  lnkmon_deadline #(.CODE_W(CODE_W), .HI_CODE(HI_CODE), .LO_CODE(LO_CODE)) u_dl (
    .clk(clk), .rst_n(rs2_q), .chg_ok(chg_ok), .tgt(stim_i), .last(last),
    .code(code_i), .fail(fail)
  );

  assign legal_o = legal;
  assign fail_o  = fail & legal;

  assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rs2_q)
    fail_o |=> (fail_o || !legal_o));

endmodule

// File: tb/test_lnkmon.sv
`timescale 1ns/1ps
module test_lnkmon;
  localparam int unsigned N = 38, CW = 6, HI = 51, LO = 12;

  logic clk = 1'b0, rst_n = 1'b0, stim = 1'b0;
  logic [CW-1:0] code = '0;
  logic legal_o, fail_o;
  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  int m_k; bit m_prev, m_legal, m_arm, m_want, m_met, m_fail;

  always #2.5 clk = ~clk;

  lnkmon #(.N(N), .CODE_W(CW), .HI_CODE(HI), .LO_CODE(LO)) i_lnkmon (
    .clk(clk), .rst_n(rst_n), .stim_i(stim), .code_i(code),
    .legal_o(legal_o), .fail_o(fail_o)
  );

  function automatic bit settled(bit want, int c);
    return want ? (c >= HI) : (c <= LO);
  endfunction

  function automatic logic [CW-1:0] pick(bit want);
    int r = $urandom_range(0, 9);
    if (r == 0) return CW'($urandom_range(0, 63));
    return want ? CW'($urandom_range(HI, 63)) : CW'($urandom_range(0, LO));
  endfunction

  task automatic chk(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", t, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_k = 0; m_prev = 0; m_legal = 1; m_arm = 0; m_want = 0; m_met = 0; m_fail = 0;
  endtask

  task automatic model_step(bit b, int c);
    bit is_slot = (m_k % N) == 0;
    bit is_last = (m_k % N) == N - 1;
    if (b != m_prev && is_slot) begin
      m_arm = 1; m_want = b; m_met = 0;
    end else begin
      if (b != m_prev) m_legal = 0;
      if (settled(m_want, c)) m_met = 1;
      if (is_last && m_arm && !m_met) m_fail = 1;
    end
    m_prev = b; m_k++;
  endtask

  task automatic cyc(bit b, logic [CW-1:0] c);
    @(negedge clk); stim = b; code = c;
    @(posedge clk); model_step(b, c);
    #1;
    chk({tag, " legal"}, legal_o, m_legal);
    chk({tag, " fail"}, fail_o, m_fail && m_legal);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; stim = 0; code = '0;
    #1; model_reset();
    chk("R1 legal in reset", legal_o, 1'b1);
    chk("R1 fail in reset", fail_o, 1'b0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); @(posedge clk);
  endtask

  task automatic to_slot(logic [CW-1:0] c);
    while ((m_k % N) != 0) cyc(stim, c);
  endtask

  initial begin
    #500us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    tag = "R1"; cyc(0, 6'd0);
    chk("R1 legal after reset", legal_o, 1'b1);

    // R10: no legal toggle yet, wild codes
    tag = "R10";
    for (int i = 0; i < 3 * N; i++) cyc(0, CW'($urandom_range(20, 40)));
    chk("R10 unarmed no fail", fail_o, 1'b0);

    // R6 boundary: reached exactly on the last edge of the window
    tag = "R6"; to_slot(6'd0);
    cyc(1, 6'd0);
    for (int i = 1; i < N - 1; i++) cyc(1, 6'd0);
    cyc(1, 6'd63);
    chk("R6 reached on last edge passes", fail_o, 1'b0);

    // R7: toggle to 0, never low enough
    tag = "R7"; to_slot(6'd63);
    cyc(0, 6'd63);
    for (int i = 1; i < N; i++) cyc(0, 6'd13);
    chk("R7 code above LO fails", fail_o, 1'b1);
    tag = "R9";
    for (int i = 0; i < N + 3; i++) cyc(0, 6'd0);
    chk("R9 fail stays set", fail_o, 1'b1);

    // R8: level on the toggle edge only
    do_reset(); tag = "R8";
    cyc(1, 6'd63);
    for (int i = 1; i < N; i++) cyc(1, 6'd50);
    chk("R8 toggle-edge code ignored", fail_o, 1'b1);

    // R11: reached once early, later windows without toggle
    do_reset(); tag = "R11";
    cyc(1, 6'd0);
    cyc(1, 6'd51);
    for (int i = 0; i < 2 * N; i++) cyc(1, 6'd0);
    chk("R11 early reach holds", fail_o, 1'b0);

    // R2: toggle on slot edge N is legal
    do_reset(); tag = "R2";
    for (int i = 0; i < N; i++) cyc(0, 6'd0);
    cyc(1, 6'd63);
    chk("R2 toggle on slot N legal", legal_o, 1'b1);

    // R3/R5/R4: illegal toggle mid-window, then a window that would fail
    tag = "R3";
    cyc(1, 6'd0); cyc(1, 6'd0);
    cyc(0, 6'd0);
    chk("R3 off-slot toggle clears legal", legal_o, 1'b0);
    tag = "R5";
    for (int i = 0; i < 2 * N; i++) cyc(1, 6'd20);
    chk("R5 fail masked", fail_o, 1'b0);
    chk("R4 legal stays low", legal_o, 1'b0);

    // R6 late: reach one edge past the window
    do_reset(); tag = "R6";
    cyc(1, 6'd0);
    for (int i = 1; i < N; i++) cyc(1, 6'd40);
    cyc(1, 6'd63);
    chk("R6 reach after window fails", fail_o, 1'b1);

    // random mix
    do_reset(); tag = "R6 random";
    for (int i = 0; i < 4000; i++) begin
      bit b = stim;
      if ((m_k % N) == 0 && $urandom_range(0, 1)) b = ~stim;
      else if ($urandom_range(0, 1999) == 0) b = ~stim;
      cyc(b, pick(m_arm ? m_want : b));
    end
    tag = "R7 random";
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int i = 0; i < 6 * N; i++) begin
        bit b = stim;
        if ((m_k % N) == 0 && $urandom_range(0, 2) == 0) b = ~stim;
        cyc(b, pick(m_want ^ ($urandom_range(0, 30) == 0)));
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
  end
endmodule